// File: doc/BRIEF.md
# Byte-Lane Multiplexed Output Port

This block is an 8-bit output register on a CPU that has a 16-bit data bus and a byte-addressed I/O space. It answers at two adjacent I/O addresses. The least significant address bit chooses which half of the CPU data bus is copied into the single 8-bit register. The even address (DCh) takes the upper data byte, and the odd address (DDh) takes the lower data byte. Because the block uses both addresses, every address in the pair reaches the peripheral and none is wasted.

The CPU writes to the port by driving an I/O address and write data, then pulling the active-low I/O write strobe low. The block captures the selected byte on the first clock edge at which the strobe is low and the address decodes. It takes no further byte until the strobe has gone high again. A one-cycle pulse marks every accepted write, so a peripheral or a monitor can react to it.

Top module: `lane_mux_out_port`

## Requirements
- R1: A synchronous reset sets the register to 00h and the write pulse to 0. Reset wins over a valid write presented at the same clock edge.
- R2: A write to address DCh (address bit 0 = 0) loads data bits 15..8 into the register.
- R3: A write to address DDh (address bit 0 = 1) loads data bits 7..0 into the register.
- R4: A full 16-bit write to DCh keeps only the upper byte. The value of data bits 7..0 has no effect on the register.
- R5: While the write strobe is high (inactive), the register does not change and no pulse is produced, even at DCh or DDh.
- R6: All 8 address bits are decoded. A write at an address whose upper seven bits differ from those of DCh (for example DEh, DFh, 5Ch or FCh) leaves the register unchanged and produces no pulse.
- R7: Each low period of the strobe loads the register at most once. Data or lane changes later in the same low period are ignored, and the next load needs the strobe to return high first.
- R8: An accepted write raises the write pulse for exactly one cycle. The pulse is high in the same cycle in which the new register value first appears.
- R9: The load happens at the first edge within a strobe low period at which the address matches. A low period that starts at a foreign address still loads once the address moves to DCh or DDh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | CPU I/O address byte |
| io_wdata | input | 16 | CPU write data, both byte lanes |
| io_wr_n | input | 1 | I/O write strobe, active low |
| port_q | output | 8 | Latched peripheral register value |
| port_wr_pulse | output | 1 | One-cycle flag for each accepted write |

## Verification
Two functions can fall in the same cycle. The first pair is reset and an accepted write. The bench sets a valid strobe at DCh and asserts reset at the same edge, then expects 00h and no pulse. The second pair is the once-per-strobe lockout and an address that changes during one strobe low period. The bench holds the strobe low while it moves the address from a foreign value to DDh, and later while the data changes after a load. It judges the register value and counts pulse cycles at the falling edge after each rising edge.

// File: rtl/lane_port_pkg.sv
package lane_port_pkg;

    localparam int unsigned PORT_ADDR_W = 8;
    localparam int unsigned PORT_DATA_W = 16;
    localparam int unsigned PORT_LANE_W = 8;
    localparam logic [PORT_ADDR_W-1:0] PORT_BASE = 8'hDC;

    // Strobe gate state: armed waits for a matching low strobe,
    // spent waits for the strobe to rise again.
    typedef enum logic {
        GATE_ARMED = 1'b0,
        GATE_SPENT = 1'b1
    } gate_state_e;

    // Big-endian lane choice: offset 0 selects the most significant lane.
    function automatic int unsigned lane_for_offset(
        input int unsigned offset,
        input int unsigned num_lanes
    );
        return num_lanes - 1 - offset;
    endfunction

endpackage

// File: rtl/port_addr_decode.sv
module port_addr_decode #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned OFS_W  = 1,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hDC
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    localparam int unsigned TAG_W = ADDR_W - OFS_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:OFS_W];

    always_comb begin
        hit = (addr[ADDR_W-1:OFS_W] == BASE_TAG);
        ofs = addr[OFS_W-1:0];
    end

endmodule

// File: rtl/wr_once_gate.sv
module wr_once_gate
    import lane_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    input  logic hit,
    output logic accept
);
    gate_state_e state_q;
    gate_state_e state_d;

    always_comb begin
        accept  = (state_q == GATE_ARMED) && !wr_n && hit;
        state_d = state_q;
        if (wr_n) begin
            state_d = GATE_ARMED;
        end else if (accept) begin
            state_d = GATE_SPENT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);  // R7
    AST_REARM_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        (wr_n && !$past(rst)) |=> (!wr_n && hit) |-> accept);  // R9

endmodule

// File: rtl/lane_capture_reg.sv
module lane_capture_reg
    import lane_port_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned NUM_LANES = DATA_W / LANE_W,
    localparam int unsigned OFS_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANE_W-1:0] q,
    output logic              wr_pulse
);
    logic [LANE_W-1:0] lanes [NUM_LANES];
    logic [LANE_W-1:0] sel_byte;

    for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
        assign lanes[li] = wdata[li*LANE_W +: LANE_W];
    end

    always_comb begin
        sel_byte = '0;
        for (int unsigned oi = 0; oi < NUM_LANES; oi++) begin
            if (ofs == OFS_W'(oi)) begin
                sel_byte = lanes[lane_for_offset(oi, NUM_LANES)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            wr_pulse <= 1'b0;
        end else begin
            wr_pulse <= accept;
            if (accept) begin
                q <= sel_byte;
            end
        end
    end

    AST_EVEN_TAKES_HIGH: assert property (@(posedge clk) disable iff (rst)
        (accept && ofs == '0) |=> q == $past(wdata[DATA_W-1 -: LANE_W]));  // R2
    AST_ODD_TAKES_LOW: assert property (@(posedge clk) disable iff (rst)
        (accept && ofs == OFS_W'(NUM_LANES-1)) |=> q == $past(wdata[LANE_W-1:0]));  // R3
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(q));  // R6
    AST_PULSE_MARKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        accept |=> wr_pulse);  // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);  // R8

endmodule

// File: rtl/lane_mux_out_port.sv
module lane_mux_out_port
    import lane_port_pkg::*;
#(
    parameter int unsigned ADDR_W = PORT_ADDR_W,
    parameter int unsigned DATA_W = PORT_DATA_W,
    parameter int unsigned LANE_W = PORT_LANE_W,
    parameter logic [ADDR_W-1:0] BASE_ADDR = PORT_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr_n,
    output logic [LANE_W-1:0] port_q,
    output logic              port_wr_pulse
);
    localparam int unsigned NUM_LANES = DATA_W / LANE_W;
    localparam int unsigned OFS_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic             addr_hit;
    logic [OFS_W-1:0] addr_ofs;
    logic             wr_accept;

    port_addr_decode #(
        .ADDR_W   (ADDR_W),
        .OFS_W    (OFS_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(io_addr),
        .hit (addr_hit),
        .ofs (addr_ofs)
    );

    wr_once_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .wr_n  (io_wr_n),
        .hit   (addr_hit),
        .accept(wr_accept)
    );

    lane_capture_reg #(
        .DATA_W(DATA_W),
        .LANE_W(LANE_W)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .accept  (wr_accept),
        .ofs     (addr_ofs),
        .wdata   (io_wdata),
        .q       (port_q),
        .wr_pulse(port_wr_pulse)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (1'b0)
        $past(rst) |-> (port_q == '0 && !port_wr_pulse));  // R1
    AST_IDLE_STROBE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        io_wr_n |=> !port_wr_pulse);  // R5

endmodule

// File: tb/lane_mux_out_port_tb.sv
module lane_mux_out_port_tb;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  io_addr = 8'h00;
    logic [15:0] io_wdata = 16'h0000;
    logic        io_wr_n = 1'b1;
    logic [7:0]  port_q;
    logic        port_wr_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    lane_mux_out_port u_dut (
        .clk          (clk),
        .rst          (rst),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_wr_n      (io_wr_n),
        .port_q       (port_q),
        .port_wr_pulse(port_wr_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one strobe low for a single edge; sample at the next falling edge.
    task automatic strobe_once(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_strobe();
        io_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset value", port_q, 8'h00);
        check("R1 reset pulse", {7'b0, port_wr_pulse}, 8'h00);
    endtask

    task automatic t_even_lane();
        strobe_once(8'hDC, 16'hA55A);
        check("R2 even takes upper byte", port_q, 8'hA5);
        check("R8 pulse with new value", {7'b0, port_wr_pulse}, 8'h01);
        release_strobe();
        check("R8 pulse lasts one cycle", {7'b0, port_wr_pulse}, 8'h00);
    endtask

    task automatic t_odd_lane();
        strobe_once(8'hDD, 16'h1234);
        check("R3 odd takes lower byte", port_q, 8'h34);
        release_strobe();
    endtask

    task automatic t_low_byte_lost();
        strobe_once(8'hDC, 16'h00FF);
        check("R4 low byte discarded", port_q, 8'h00);
        release_strobe();
        strobe_once(8'hDC, 16'h7E81);
        check("R4 upper byte kept", port_q, 8'h7E);
        release_strobe();
    endtask

    task automatic t_strobe_idle();
        @(negedge clk);
        io_addr = 8'hDD; io_wdata = 16'hFFC3;
        @(negedge clk);
        check("R5 idle strobe value", port_q, 8'h7E);
        check("R5 idle strobe pulse", {7'b0, port_wr_pulse}, 8'h00);
    endtask

    task automatic t_foreign_addr();
        logic [7:0] foreign [4] = '{8'hDE, 8'hDF, 8'h5C, 8'hFC};
        for (int i = 0; i < 4; i++) begin
            strobe_once(foreign[i], 16'h9999);
            check($sformatf("R6 foreign %h value", foreign[i]), port_q, 8'h7E);
            check($sformatf("R6 foreign %h pulse", foreign[i]), {7'b0, port_wr_pulse}, 8'h00);
            release_strobe();
        end
    endtask

    task automatic t_once_per_strobe();
        int pulses;
        strobe_once(8'hDD, 16'h0011);
        pulses = int'(port_wr_pulse);
        for (int i = 0; i < 4; i++) begin
            io_wdata = 16'h2222 + 16'(i);
            io_addr  = (i % 2 == 0) ? 8'hDC : 8'hDD;
            @(negedge clk);
            pulses += int'(port_wr_pulse);
        end
        check("R7 first byte kept", port_q, 8'h11);
        check("R7 single pulse", 8'(pulses), 8'h01);
        release_strobe();
        strobe_once(8'hDD, 16'h0066);
        check("R7 rearmed after rise", port_q, 8'h66);
        release_strobe();
    endtask

    task automatic t_late_match();
        strobe_once(8'h10, 16'h4400);
        check("R9 foreign start no load", port_q, 8'h66);
        io_addr = 8'hDD; io_wdata = 16'h0055;
        @(negedge clk);
        check("R9 late match loads", port_q, 8'h55);
        check("R9 late match pulse", {7'b0, port_wr_pulse}, 8'h01);
        release_strobe();
    endtask

    task automatic t_reset_vs_write();
        @(negedge clk);
        io_addr = 8'hDC; io_wdata = 16'hBB00; io_wr_n = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R1 reset wins value", port_q, 8'h00);
        check("R1 reset wins pulse", {7'b0, port_wr_pulse}, 8'h00);
        rst = 1'b0; io_wr_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_even_lane();
        t_odd_lane();
        t_low_byte_lost();
        t_strobe_idle();
        t_foreign_addr();
        t_once_per_strobe();
        t_late_match();
        t_reset_vs_write();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule